// File: doc/BRIEF.md
# Multi-Channel PWM Register File with Synchronized Commit

This block is the programmable register set of a pulse-width modulator with up to eight channels. It sits on a simple APB-style slave port. Each channel has a period, a compare value, a dead-band compare value and a control word. The period and the two compares are kept twice. Software writes a shadow copy. The active copy that feeds the counters takes the shadow value only while that channel's hold-update flag in the global control word is clear. Software sets the hold flags of the channels it wants to change, rewrites their values, then clears the flags in one write. All the released channels then switch on the same clock edge.

The global part holds an enable for the whole core and a small bank of prescaler values. The prescalers are reached indirectly: a select field in the global control word picks which prescaler the scaler register reads or writes. An interrupt-pending register collects one event bit per channel and is cleared by writing ones. Two read-only capability words report how the block was built. A waveform-control word is kept as plain storage for the waveform unit. The counters, the output shaping and the waveform memory are outside this block. It exports the active values and takes one interrupt event line per channel.

Top module: `pwm_sync_regs`

## Requirements
- R1: After reset the core enable is 0, every channel shadow, active and control register is 0, the pending bits are 0, the waveform word is 0 and every prescaler holds all ones.
- R2: A write takes effect on the clock edge that ends an access phase (psel, penable and pwrite high). Reads are combinational from paddr. Byte offsets are: global control 0x00, scaler 0x04, pending 0x08, capability 1 0x0C, capability 2 0x10 (reads 0), waveform word 0x14. Channel n starts at 0x20 + 16·n and holds period +0x0, compare +0x4, dead-band +0x8 and control +0xC.
- R3: While hold bit 12+n of global control is 1, channel n's active period, compare and dead-band outputs do not change, whatever is written to the channel.
- R4: While hold is 0, an active value equals the shadow value one clock after it was written. Clearing several hold bits in one control write loads all the released channels on the same edge, one clock after that write.
- R5: A read of a channel period, compare or dead-band register returns the shadow value, including while hold is set.
- R6: Channel control bits 1 and 6 keep their value on a write when the stored bit 0 is 1. Otherwise a write stores the data masked to 0x3FFFFF7F (bit 7 and bits 31:30 read 0), and the stored word drives act_ctrl at once.
- R7: Global control bit 0 drives core_en and bits 10:8 form the prescaler select. The scaler register reads and writes the selected prescaler. With a select at or above NPSC, writes are ignored and reads return 0.
- R8: An event on irq_evt[n] sets pending bit n. Writing 1 to a pending bit clears it, and writing all ones clears every bit. An event and a clear on the same edge leave the bit set.
- R9: Capability 1 reads NCH-1 in bits 2:0, NPSC-1 in bits 15:13, the interrupt-separation code in bits 26:25 and the dual-compare flag in bit 27, with all other bits 0.
- R10: Addresses that map to no register read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| irq_evt | input | NCH | Per-channel interrupt event |
| core_en | output | 1 | Global core enable |
| psc_val | output | NPSC·PSC_W | Prescaler values, prescaler p at bits p·PSC_W |
| irq_pend | output | NCH | Pending interrupt bits |
| wave_cfg | output | 32 | Waveform control word |
| act_period | output | NCH·CNT_W | Active periods |
| act_comp | output | NCH·CNT_W | Active compare values |
| act_db | output | NCH·CNT_W | Active dead-band compare values |
| act_ctrl | output | NCH·30 | Channel control words |

## Verification
The properties assume that psel, penable and pwrite only reach the registers together during a proper access phase. They also assume that irq_evt is a level sampled on each edge, with no handshake. The commit property relies on no second write to the same channel register on the next cycle, and on the hold bit not being raised in between. The stimulus keeps to these conditions: each access is an idle, setup and access sequence with inputs changed 1 ns after an edge, and event pulses last exactly one clock.

// File: rtl/pwm_rf_pkg.sv
package pwm_rf_pkg;
   localparam logic [7:0] OFS_CTRL = 8'h00;
   localparam logic [7:0] OFS_SCL  = 8'h04;
   localparam logic [7:0] OFS_PEND = 8'h08;
   localparam logic [7:0] OFS_CAP1 = 8'h0C;
   localparam logic [7:0] OFS_CAP2 = 8'h10;
   localparam logic [7:0] OFS_WAVE = 8'h14;
   localparam int         OFS_CH0  = 32;
   localparam int         CH_STRIDE = 16;

   localparam int CCTRL_W = 30;
   localparam logic [CCTRL_W-1:0] CCTRL_MASK = 30'h3FFF_FF7F;
   localparam int B_EN   = 0;
   localparam int B_POL  = 1;
   localparam int B_METH = 6;

   localparam int G_SEL_LSB  = 8;
   localparam int G_HOLD_LSB = 12;

   typedef enum logic [1:0] {
      CR_PERIOD = 2'd0,
      CR_COMP   = 2'd1,
      CR_DB     = 2'd2,
      CR_CTRL   = 2'd3
   } chan_reg_e;
endpackage

// File: rtl/pwm_rf_chan.sv
module pwm_rf_chan
   import pwm_rf_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hold,
   input  logic               wr_en,
   input  chan_reg_e          sel,
   input  logic [31:0]        wdata,
   output logic [31:0]        rd_data,
   output logic [CNT_W-1:0]   act_period,
   output logic [CNT_W-1:0]   act_comp,
   output logic [CNT_W-1:0]   act_db,
   output logic [CCTRL_W-1:0] ctrl_q
);
   logic [CNT_W-1:0]   sh_period, sh_comp, sh_db;
   logic [CCTRL_W-1:0] ctrl_nxt;

   // polarity and method are frozen while the channel runs
   always_comb begin
      ctrl_nxt = wdata[CCTRL_W-1:0] & CCTRL_MASK;
      if (ctrl_q[B_EN]) begin
         ctrl_nxt[B_POL]  = ctrl_q[B_POL];
         ctrl_nxt[B_METH] = ctrl_q[B_METH];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_period <= '0;
         sh_comp   <= '0;
         sh_db     <= '0;
         ctrl_q    <= '0;
      end else if (wr_en) begin
         case (sel)
            CR_PERIOD: sh_period <= wdata[CNT_W-1:0];
            CR_COMP:   sh_comp   <= wdata[CNT_W-1:0];
            CR_DB:     sh_db     <= wdata[CNT_W-1:0];
            default:   ctrl_q    <= ctrl_nxt;
         endcase
      end
   end

   // shadow-to-active transfer, gated by the hold flag
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_period <= '0;
         act_comp   <= '0;
         act_db     <= '0;
      end else if (!hold) begin
         act_period <= sh_period;
         act_comp   <= sh_comp;
         act_db     <= sh_db;
      end
   end

   always_comb begin
      case (sel)
         CR_PERIOD: rd_data = 32'(sh_period);
         CR_COMP:   rd_data = 32'(sh_comp);
         CR_DB:     rd_data = 32'(sh_db);
         default:   rd_data = 32'(ctrl_q);
      endcase
   end
endmodule

// File: rtl/pwm_rf_glob.sv
module pwm_rf_glob
   import pwm_rf_pkg::*;
#(
   parameter int NCH   = 4,
   parameter int NPSC  = 3,
   parameter int PSC_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_ctrl,
   input  logic                  wr_scl,
   input  logic                  wr_pend,
   input  logic                  wr_wave,
   input  logic [31:0]           wdata,
   input  logic [NCH-1:0]        irq_evt,
   output logic                  core_en,
   output logic [NCH-1:0]        hold,
   output logic [NPSC*PSC_W-1:0] psc_flat,
   output logic [NCH-1:0]        pend,
   output logic [31:0]           wave_cfg,
   output logic [31:0]           ctrl_rd,
   output logic [31:0]           scl_rd
);
   logic [2:0] sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         core_en <= 1'b0;
         sel_q   <= '0;
         hold    <= '0;
      end else if (wr_ctrl) begin
         core_en <= wdata[0];
         sel_q   <= wdata[G_SEL_LSB +: 3];
         hold    <= wdata[G_HOLD_LSB +: NCH];
      end
   end

   for (genvar p = 0; p < NPSC; p++) begin : g_psc
      logic [PSC_W-1:0] val;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            val <= '1;
         else if (wr_scl && sel_q == 3'(p))
            val <= wdata[PSC_W-1:0];
      end
      assign psc_flat[p*PSC_W +: PSC_W] = val;
   end

   always_comb begin
      scl_rd = '0;
      for (int p = 0; p < NPSC; p++)
         if (sel_q == 3'(p)) scl_rd = 32'(psc_flat[p*PSC_W +: PSC_W]);
   end

   // a new event wins over a clear on the same edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend <= '0;
      else
         pend <= (pend & ~(wr_pend ? wdata[NCH-1:0] : '0)) | irq_evt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        wave_cfg <= '0;
      else if (wr_wave)  wave_cfg <= wdata;
   end

   assign ctrl_rd = 32'(core_en) | (32'(sel_q) << G_SEL_LSB) | (32'(hold) << G_HOLD_LSB);
endmodule

// File: rtl/pwm_sync_regs.sv
module pwm_sync_regs
   import pwm_rf_pkg::*;
#(
   parameter int NCH      = 4,
   parameter int CNT_W    = 16,
   parameter int NPSC     = 3,
   parameter int PSC_W    = 16,
   parameter int DUAL_CMP = 1,
   parameter int SEP_MODE = 1,
   parameter int ADDR_W   = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   psel,
   input  logic                   penable,
   input  logic                   pwrite,
   input  logic [ADDR_W-1:0]      paddr,
   input  logic [31:0]            pwdata,
   output logic [31:0]            prdata,
   input  logic [NCH-1:0]         irq_evt,
   output logic                   core_en,
   output logic [NPSC*PSC_W-1:0]  psc_val,
   output logic [NCH-1:0]         irq_pend,
   output logic [31:0]            wave_cfg,
   output logic [NCH*CNT_W-1:0]   act_period,
   output logic [NCH*CNT_W-1:0]   act_comp,
   output logic [NCH*CNT_W-1:0]   act_db,
   output logic [NCH*CCTRL_W-1:0] act_ctrl
);
   localparam int CH_END = OFS_CH0 + CH_STRIDE * NCH;
   localparam logic [31:0] CAP1_WORD = 32'(NCH - 1) | (32'(NPSC - 1) << 13)
                                     | (32'(SEP_MODE) << 25) | (32'(DUAL_CMP) << 27);

   if (NCH < 1 || NCH > 8)         begin : g_bad_nch  $error("NCH must be 1..8");     end
   if (NPSC < 1 || NPSC > 8)       begin : g_bad_npsc $error("NPSC must be 1..8");    end
   if (CNT_W < 1 || CNT_W > 32)    begin : g_bad_cnt  $error("CNT_W must be 1..32");  end
   if (PSC_W < 1 || PSC_W > 32)    begin : g_bad_psc  $error("PSC_W must be 1..32");  end
   if (ADDR_W < 8)                 begin : g_bad_addr $error("ADDR_W must be >= 8");  end
   if (SEP_MODE < 0 || SEP_MODE > 3) begin : g_bad_sep $error("SEP_MODE must be 0..3"); end
   if (DUAL_CMP < 0 || DUAL_CMP > 1) begin : g_bad_dual $error("DUAL_CMP must be 0..1"); end

   logic                wr;
   logic [ADDR_W-1:0]   wa;
   logic                in_ch;
   logic [ADDR_W-1:0]   ch_off;
   logic [ADDR_W-5:0]   ch_idx;
   chan_reg_e           csel;
   logic [NCH-1:0]      hold_w;
   logic [NCH*32-1:0]   ch_rd_flat;
   logic [31:0]         ctrl_rd, scl_rd;

   assign wr     = psel & penable & pwrite;
   assign wa     = {paddr[ADDR_W-1:2], 2'b00};
   assign in_ch  = (int'(wa) >= OFS_CH0) && (int'(wa) < CH_END);
   assign ch_off = wa - ADDR_W'(OFS_CH0);
   assign ch_idx = ch_off[ADDR_W-1:4];
   assign csel   = chan_reg_e'(paddr[3:2]);

   pwm_rf_glob #(.NCH(NCH), .NPSC(NPSC), .PSC_W(PSC_W)) u_glob (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ctrl  (wr && !in_ch && wa == ADDR_W'(OFS_CTRL)),
      .wr_scl   (wr && !in_ch && wa == ADDR_W'(OFS_SCL)),
      .wr_pend  (wr && !in_ch && wa == ADDR_W'(OFS_PEND)),
      .wr_wave  (wr && !in_ch && wa == ADDR_W'(OFS_WAVE)),
      .wdata    (pwdata),
      .irq_evt  (irq_evt),
      .core_en  (core_en),
      .hold     (hold_w),
      .psc_flat (psc_val),
      .pend     (irq_pend),
      .wave_cfg (wave_cfg),
      .ctrl_rd  (ctrl_rd),
      .scl_rd   (scl_rd)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      pwm_rf_chan #(.CNT_W(CNT_W)) u_chan (
         .clk        (clk),
         .rst_n      (rst_n),
         .hold       (hold_w[i]),
         .wr_en      (wr && in_ch && ch_idx == (ADDR_W-4)'(i)),
         .sel        (csel),
         .wdata      (pwdata),
         .rd_data    (ch_rd_flat[i*32 +: 32]),
         .act_period (act_period[i*CNT_W +: CNT_W]),
         .act_comp   (act_comp[i*CNT_W +: CNT_W]),
         .act_db     (act_db[i*CNT_W +: CNT_W]),
         .ctrl_q     (act_ctrl[i*CCTRL_W +: CCTRL_W])
      );
   end

   always_comb begin
      prdata = '0;
      if (in_ch) begin
         for (int i = 0; i < NCH; i++)
            if (ch_idx == (ADDR_W-4)'(i)) prdata = ch_rd_flat[i*32 +: 32];
      end else begin
         case (wa)
            ADDR_W'(OFS_CTRL): prdata = ctrl_rd;
            ADDR_W'(OFS_SCL):  prdata = scl_rd;
            ADDR_W'(OFS_PEND): prdata = 32'(irq_pend);
            ADDR_W'(OFS_CAP1): prdata = CAP1_WORD;
            ADDR_W'(OFS_CAP2): prdata = '0;
            ADDR_W'(OFS_WAVE): prdata = wave_cfg;
            default:           prdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/pwm_sync_regs_chk.sv
module pwm_sync_regs_chk #(
   parameter int NCH    = 4,
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 psel,
   input logic                 penable,
   input logic                 pwrite,
   input logic [ADDR_W-1:0]    paddr,
   input logic [31:0]          pwdata,
   input logic [NCH-1:0]       irq_evt,
   input logic [NCH-1:0]       irq_pend,
   input logic [NCH-1:0]       hold,
   input logic [NCH*CNT_W-1:0] act_period,
   input logic [NCH*CNT_W-1:0] act_comp,
   input logic [NCH*CNT_W-1:0] act_db,
   input logic [NCH*30-1:0]    act_ctrl
);
   logic wr_any, wr_pend;
   assign wr_any  = psel & penable & pwrite;
   assign wr_pend = wr_any && {paddr[ADDR_W-1:2], 2'b00} == ADDR_W'(8'h08);

   for (genvar i = 0; i < NCH; i++) begin : g_p
      logic wr_per;
      assign wr_per = wr_any && paddr == ADDR_W'(32 + 16 * i);

      a_r3_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
         hold[i] |=> $stable(act_period[i*CNT_W +: CNT_W]) && $stable(act_comp[i*CNT_W +: CNT_W])
                     && $stable(act_db[i*CNT_W +: CNT_W]));

      a_r4_commit: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_per && !hold[i]) |=> ##1 ($past(hold[i]) ||
            act_period[i*CNT_W +: CNT_W] == $past(pwdata[CNT_W-1:0], 2)));

      a_r6_lock: assert property (@(posedge clk) disable iff (!rst_n)
         act_ctrl[i*30] |=> $stable(act_ctrl[i*30+1]) && $stable(act_ctrl[i*30+6]));

      a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         irq_evt[i] |=> irq_pend[i]);

      a_r8_keep: assert property (@(posedge clk) disable iff (!rst_n)
         (irq_pend[i] && !(wr_pend && pwdata[i])) |=> irq_pend[i]);
   end
endmodule

bind pwm_sync_regs pwm_sync_regs_chk #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .psel       (psel),
   .penable    (penable),
   .pwrite     (pwrite),
   .paddr      (paddr),
   .pwdata     (pwdata),
   .irq_evt    (irq_evt),
   .irq_pend   (irq_pend),
   .hold       (hold_w),
   .act_period (act_period),
   .act_comp   (act_comp),
   .act_db     (act_db),
   .act_ctrl   (act_ctrl)
);

// File: tb/sim_pwm_sync_regs.sv
module sim_pwm_sync_regs;
   localparam int NCH = 4, CNT_W = 16, NPSC = 3, PSC_W = 16, ADDR_W = 8;

   logic clk = 0, rst_n = 0;
   logic psel = 0, penable = 0, pwrite = 0;
   logic [ADDR_W-1:0] paddr = '0;
   logic [31:0] pwdata = '0, prdata;
   logic [NCH-1:0] irq_evt = '0, irq_pend;
   logic core_en;
   logic [NPSC*PSC_W-1:0] psc_val;
   logic [31:0] wave_cfg;
   logic [NCH*CNT_W-1:0] act_period, act_comp, act_db;
   logic [NCH*30-1:0] act_ctrl;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;
   logic [31:0] exp_q[$], act_q[$];
   string tag_q[$];

   always #5 clk = ~clk;

   pwm_sync_regs u0 (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq_evt(irq_evt),
      .core_en(core_en), .psc_val(psc_val), .irq_pend(irq_pend), .wave_cfg(wave_cfg),
      .act_period(act_period), .act_comp(act_comp), .act_db(act_db), .act_ctrl(act_ctrl));

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic apb_write(input logic [7:0] a, input logic [31:0] d, input logic [NCH-1:0] ev = '0);
      @(posedge clk); #1;
      psel = 1; pwrite = 1; paddr = a; pwdata = d;
      @(posedge clk); #1;
      penable = 1; irq_evt = ev;
      @(posedge clk); #1;
      psel = 0; penable = 0; pwrite = 0; irq_evt = '0;
   endtask

   // driver side: push expectation; the read result goes to the actual stream
   task automatic apb_read(input logic [7:0] a, input logic [31:0] e, input string tag);
      @(posedge clk); #1;
      psel = 1; pwrite = 0; paddr = a;
      @(posedge clk); #1;
      penable = 1;
      exp_q.push_back(e); tag_q.push_back(tag);
      act_q.push_back(prdata);
      @(posedge clk); #1;
      psel = 0; penable = 0;
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   // monitor: compare read results against the scoreboard queue
   initial begin
      forever begin
         wait (act_q.size() > 0);
         chk(tag_q.pop_front(), 64'(act_q.pop_front()), 64'(exp_q.pop_front()));
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1;
      tick(1);
      // R1 reset state
      chk("R1 core_en", 64'(core_en), 64'd0);
      chk("R1 act_period", 64'(act_period), 64'd0);
      chk("R1 psc_val", 64'(psc_val), 64'hFFFF_FFFF_FFFF);
      chk("R1 irq_pend", 64'(irq_pend), 64'd0);
      apb_read(8'h00, 32'h0, "R1 ctrl read");
      apb_read(8'h04, 32'h0000_FFFF, "R1 scaler read");
      apb_read(8'h30, 32'h0, "R1 ch1 period");
      // R9 capabilities, R2 cap2
      apb_read(8'h0C, 32'h0A00_4003, "R9 cap1");
      apb_read(8'h10, 32'h0, "R2 cap2");
      // R2 waveform word and channel map
      apb_write(8'h14, 32'h1234_5678);
      apb_read(8'h14, 32'h1234_5678, "R2 wave read");
      chk("R2 wave_cfg", 64'(wave_cfg), 64'h1234_5678);
      apb_write(8'h24, 32'h11);
      apb_write(8'h28, 32'h22);
      apb_read(8'h24, 32'h11, "R2 ch0 compare");
      apb_read(8'h28, 32'h22, "R2 ch0 deadband");
      // R10 unmapped
      apb_read(8'h18, 32'h0, "R10 gap read");
      apb_write(8'h60, 32'hDEAD_BEEF);
      apb_read(8'h60, 32'h0, "R10 beyond channels");
      // R4 immediate commit
      apb_write(8'h30, 32'h0ABC);
      chk("R4 ch1 not yet", 64'(act_period[16 +: 16]), 64'h0);
      tick(1);
      chk("R4 ch1 committed", 64'(act_period[16 +: 16]), 64'h0ABC);
      chk("R4 ch0 compare", 64'(act_comp[0 +: 16]), 64'h11);
      // R3/R5 hold ch0 and ch2
      apb_write(8'h00, 32'h0000_5001);
      apb_read(8'h00, 32'h0000_5001, "R7 ctrl readback");
      chk("R7 core_en", 64'(core_en), 64'd1);
      apb_write(8'h20, 32'h100);
      apb_write(8'h40, 32'h200);
      apb_write(8'h30, 32'h300);
      tick(3);
      chk("R3 ch0 held", 64'(act_period[0 +: 16]), 64'h0);
      chk("R3 ch2 held", 64'(act_period[32 +: 16]), 64'h0);
      chk("R4 ch1 free", 64'(act_period[16 +: 16]), 64'h300);
      apb_read(8'h20, 32'h100, "R5 shadow read");
      apb_write(8'h00, 32'h1);
      chk("R4 release not yet", 64'(act_period[0 +: 16]), 64'h0);
      tick(1);
      chk("R4 ch0 released", 64'(act_period[0 +: 16]), 64'h100);
      chk("R4 ch2 released", 64'(act_period[32 +: 16]), 64'h200);
      // R6 control lock
      apb_write(8'h4C, 32'h43);
      apb_read(8'h4C, 32'h43, "R6 set while disabled");
      chk("R6 act_ctrl", 64'(act_ctrl[60 +: 30]), 64'h43);
      apb_write(8'h4C, 32'h0);
      apb_read(8'h4C, 32'h42, "R6 locked bits kept");
      apb_write(8'h4C, 32'h0);
      apb_read(8'h4C, 32'h0, "R6 cleared when idle");
      apb_write(8'h4C, 32'hFFFF_FFFF);
      apb_read(8'h4C, 32'h3FFF_FF7F, "R6 mask");
      // R7 prescalers
      apb_write(8'h00, 32'h201);
      apb_write(8'h04, 32'h1234);
      apb_read(8'h04, 32'h1234, "R7 scaler sel2");
      chk("R7 psc_val", 64'(psc_val), 64'h1234_FFFF_FFFF);
      apb_write(8'h00, 32'h501);
      apb_write(8'h04, 32'h9999);
      apb_read(8'h04, 32'h0, "R7 bad select read");
      chk("R7 bad select ignored", 64'(psc_val), 64'h1234_FFFF_FFFF);
      // R8 pending
      @(posedge clk); #1; irq_evt = 4'b1010;
      @(posedge clk); #1; irq_evt = '0;
      chk("R8 set", 64'(irq_pend), 64'hA);
      apb_write(8'h08, 32'hA, 4'b0010);
      apb_read(8'h08, 32'h2, "R8 set wins over clear");
      apb_write(8'h08, 32'hFFFF_FFFF);
      chk("R8 clear all", 64'(irq_pend), 64'h0);
      #1;
      wait (act_q.size() == 0);
      #1;
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule